// File: doc/BRIEF.md
# Serial ADC Lane Word Assembler

This block sits behind a 1:8 deserializer on one serial ADC lane. Each cycle of the divided clock (one quarter of the serial bit clock, with data on both edges) it receives three 8-bit slices: sample data, frame clock and valid. Bit 7 of each slice is the earliest bit on the wire. While the lanes are idle, the block finds the bit rotation that aligns the frame lane with its idle square wave. It then realigns all three lanes by that rotation and cuts the data stream into words at frame-clock rising edges. Each word is emitted as one 18-bit stream beat that holds the left-justified word and a code for its size.

The block works out word lengths from the streams themselves, so one netlist serves front-ends that send 12-, 14- or 16-bit samples. Each valid-high run that follows a run of samples holds a 32-bit checksum word, and that word is sent downstream as two beats. There is no backpressure: the receiver must take a beat in every cycle in which `m_tvalid_o` is high. Several lanes are handled by instantiating the block several times.

Top module: `lvds_word_assembler`

## Requirements
- R1: While `rst_ni` is low, and after its release until a word completes, `m_tvalid_o` is 0 and `m_tdata_o` is all zeros.
- R2: No beat is produced before lock. Lock needs two consecutive eligible slices that give the same rotation. A slice is eligible when the valid bits of it and of the slice before it are all low. Its rotation is the smallest offset at which the 16-bit frame window {previous, current} holds the idle pattern 11110000. The rotation is held from lock until reset.
- R3: Once locked, the sequence of output beats for a given bit stream is the same for any placement (0 to 7) of the idle frame pattern relative to slice boundaries.
- R4: A 12-bit word w gives `m_tdata_o` = {2'b00, w[11:0], 4'b0000}.
- R5: A 14-bit word w gives `m_tdata_o` = {2'b01, w[13:0], 2'b00}.
- R6: A 16-bit word w gives `m_tdata_o` = {2'b10, w[15:0]}.
- R7: A word starts at a frame bit that is 1 after a 0 while valid is 1, with its first bit as the MSB. It ends at the next such rising edge or at the first valid-low bit. Its length is the number of bits in between.
- R8: Valid-high runs alternate: the run after a sample run is a checksum run. A 32-bit checksum word gives two beats with code 2'b11, upper half first, in consecutive cycles. A checksum run must be followed by at least 8 valid-low bits.
- R9: A word in a sample run whose length is not 12, 14 or 16, or a checksum word whose length is not 32, gives no beat and still counts for the run alternation.
- R10: With rotation 0, a word's beat appears on the fourth rising edge after the edge that samples the slice holding the bit that closes the word. A checksum's lower beat appears one edge later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Divided clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 8 | Deserialized data slice, bit 7 earliest |
| frame_i | input | 8 | Deserialized frame-clock slice |
| valid_i | input | 8 | Deserialized valid slice |
| m_tvalid_o | output | 1 | Beat valid, one cycle per beat |
| m_tdata_o | output | 18 | {size code[1:0], word[15:0]} |

## Verification
There are five register stages: input capture, realignment, word closing, formatting and output. A word's beat is therefore due on the fourth edge after the edge that samples the slice holding its closing bit, and a checksum's lower half is due one edge after its upper half. The bench drives each slice at a falling edge and reads the outputs at falling edges. It records the number of elapsed rising edges with every beat and compares it against that count, worked out from the bit index of the closing bit. The other scenarios compare the ordered beat sequence against values built while the bit stream is composed. This makes them independent of the lock delay, which depends on the rotation.

// File: rtl/lvds_wa_pkg.sv
package lvds_wa_pkg;
  typedef enum logic [1:0] {
    SZ_12  = 2'b00,
    SZ_14  = 2'b01,
    SZ_16  = 2'b10,
    SZ_CRC = 2'b11
  } size_code_e;

  localparam int unsigned LEN_SHORT = 12;
  localparam int unsigned LEN_MID   = 14;
  localparam int unsigned LEN_FULL  = 16;
  localparam int unsigned LEN_CRC   = 32;
  localparam int unsigned OUT_W     = LEN_FULL;
  localparam int unsigned ACC_W     = LEN_CRC;
  localparam int unsigned LEN_W     = $clog2(ACC_W) + 1;
  localparam int unsigned BEAT_W    = OUT_W + 2;
endpackage

// File: rtl/lvds_wa_aligner.sv
module lvds_wa_aligner #(
  parameter int unsigned SLICE_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [SLICE_W-1:0] data_i,
  input  logic [SLICE_W-1:0] frame_i,
  input  logic [SLICE_W-1:0] valid_i,
  output logic [SLICE_W-1:0] al_data_o,
  output logic [SLICE_W-1:0] al_frame_o,
  output logic [SLICE_W-1:0] al_valid_o
);
  localparam int unsigned SLIP_W = $clog2(SLICE_W);
  localparam int unsigned WIN_W  = 2 * SLICE_W;
  localparam logic [SLICE_W-1:0] IDLE_PAT = {{(SLICE_W/2){1'b1}}, {(SLICE_W/2){1'b0}}};

  logic [SLICE_W-1:0] raw_d_q, raw_f_q, raw_v_q;
  logic [SLICE_W-1:0] prv_d_q, prv_f_q, prv_v_q;
  logic [WIN_W-1:0]   win_d, win_f, win_v;
  logic               hit, elig;
  logic [SLIP_W-1:0]  cand;
  logic               have_q, locked_q;
  logic [SLIP_W-1:0]  cand_q, slip_q;
  logic [SLICE_W-1:0] al_d_q, al_f_q, al_v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_d_q <= '0; raw_f_q <= '0; raw_v_q <= '0;
      prv_d_q <= '0; prv_f_q <= '0; prv_v_q <= '0;
    end else begin
      raw_d_q <= data_i; raw_f_q <= frame_i; raw_v_q <= valid_i;
      prv_d_q <= raw_d_q; prv_f_q <= raw_f_q; prv_v_q <= raw_v_q;
    end
  end

  assign win_d = {prv_d_q, raw_d_q};
  assign win_f = {prv_f_q, raw_f_q};
  assign win_v = {prv_v_q, raw_v_q};
  assign elig  = ~|win_v;

  // lowest rotation that shows the idle frame pattern
  always_comb begin
    hit  = 1'b0;
    cand = '0;
    for (int s = 0; s < SLICE_W; s++) begin
      if (!hit && win_f[s +: SLICE_W] == IDLE_PAT) begin
        hit  = 1'b1;
        cand = SLIP_W'(s);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_q   <= 1'b0;
      cand_q   <= '0;
      locked_q <= 1'b0;
      slip_q   <= '0;
    end else if (elig) begin
      if (hit) begin
        if (have_q && cand_q == cand && !locked_q) begin
          locked_q <= 1'b1;
          slip_q   <= cand;
        end
        have_q <= 1'b1;
        cand_q <= cand;
      end else begin
        have_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      al_d_q <= '0; al_f_q <= '0; al_v_q <= '0;
    end else if (locked_q) begin
      al_d_q <= win_d[slip_q +: SLICE_W];
      al_f_q <= win_f[slip_q +: SLICE_W];
      al_v_q <= win_v[slip_q +: SLICE_W];
    end else begin
      al_d_q <= '0; al_f_q <= '0; al_v_q <= '0;
    end
  end

  assign al_data_o  = al_d_q;
  assign al_frame_o = al_f_q;
  assign al_valid_o = al_v_q;

  // R2
  slip_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |=> locked_q && $stable(slip_q));

  // R2
  unlocked_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_q |=> al_v_q == '0);
endmodule

// File: rtl/lvds_wa_packer.sv
module lvds_wa_packer
  import lvds_wa_pkg::*;
#(
  parameter int unsigned SLICE_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [SLICE_W-1:0] al_data_i,
  input  logic [SLICE_W-1:0] al_frame_i,
  input  logic [SLICE_W-1:0] al_valid_i,
  output logic               cl_vld_o,
  output logic [ACC_W-1:0]   cl_bits_o,
  output logic [LEN_W-1:0]   cl_len_o,
  output logic               cl_crc_o
);
  localparam logic [LEN_W-1:0] LEN_MAX = {LEN_W{1'b1}};

  logic [ACC_W-1:0] acc_q, acc_n;
  logic [LEN_W-1:0] cnt_q, cnt_n;
  logic             inw_q, inw_n;
  logic             fprev_q, fprev_n;
  logic             vprev_q, vprev_n;
  logic             crcrun_q, crcrun_n;
  logic             nextcrc_q, nextcrc_n;
  logic             cv_n, cc_n;
  logic [ACC_W-1:0] cb_n;
  logic [LEN_W-1:0] cl_n;
  logic             cl_vld_q, cl_crc_q;
  logic [ACC_W-1:0] cl_bits_q;
  logic [LEN_W-1:0] cl_len_q;

  // bit-serial walk over one slice, earliest bit first
  always_comb begin
    logic v, f, rise;
    acc_n     = acc_q;
    cnt_n     = cnt_q;
    inw_n     = inw_q;
    fprev_n   = fprev_q;
    vprev_n   = vprev_q;
    crcrun_n  = crcrun_q;
    nextcrc_n = nextcrc_q;
    cv_n      = 1'b0;
    cb_n      = '0;
    cl_n      = '0;
    cc_n      = 1'b0;
    for (int j = SLICE_W - 1; j >= 0; j--) begin
      v    = al_valid_i[j];
      f    = al_frame_i[j];
      rise = f & ~fprev_n;
      if (inw_n && (!v || rise)) begin
        cv_n  = 1'b1;
        cb_n  = acc_n;
        cl_n  = cnt_n;
        cc_n  = crcrun_n;
        inw_n = 1'b0;
      end
      if (v && !vprev_n) crcrun_n = nextcrc_n;
      if (vprev_n && !v) nextcrc_n = ~crcrun_n;
      if (v && rise) begin
        inw_n = 1'b1;
        acc_n = '0;
        cnt_n = '0;
      end
      if (v && inw_n) begin
        acc_n = {acc_n[ACC_W-2:0], al_data_i[j]};
        if (cnt_n != LEN_MAX) cnt_n = cnt_n + 1'b1;
      end
      fprev_n = f;
      vprev_n = v;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q     <= '0;
      cnt_q     <= '0;
      inw_q     <= 1'b0;
      fprev_q   <= 1'b1;
      vprev_q   <= 1'b0;
      crcrun_q  <= 1'b0;
      nextcrc_q <= 1'b0;
      cl_vld_q  <= 1'b0;
      cl_bits_q <= '0;
      cl_len_q  <= '0;
      cl_crc_q  <= 1'b0;
    end else begin
      acc_q     <= acc_n;
      cnt_q     <= cnt_n;
      inw_q     <= inw_n;
      fprev_q   <= fprev_n;
      vprev_q   <= vprev_n;
      crcrun_q  <= crcrun_n;
      nextcrc_q <= nextcrc_n;
      cl_vld_q  <= cv_n;
      cl_bits_q <= cb_n;
      cl_len_q  <= cl_n;
      cl_crc_q  <= cc_n;
    end
  end

  assign cl_vld_o  = cl_vld_q;
  assign cl_bits_o = cl_bits_q;
  assign cl_len_o  = cl_len_q;
  assign cl_crc_o  = cl_crc_q;

  // R7
  word_nonempty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cl_vld_q |-> cl_len_q != '0);
endmodule

// File: rtl/lvds_wa_formatter.sv
module lvds_wa_formatter
  import lvds_wa_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cl_vld_i,
  input  logic [ACC_W-1:0]  cl_bits_i,
  input  logic [LEN_W-1:0]  cl_len_i,
  input  logic              cl_crc_i,
  output logic              beat_vld_o,
  output logic [BEAT_W-1:0] beat_data_o
);
  logic             d_vld, pend;
  logic [OUT_W-1:0] d_data, pend_lo;
  size_code_e       d_code;
  logic             d_vld_q, pend_q;
  logic [OUT_W-1:0] d_data_q, pend_lo_q;
  size_code_e       d_code_q;
  logic              o_vld_q;
  logic [BEAT_W-1:0] o_data_q;

  always_comb begin
    d_vld   = 1'b0;
    d_data  = '0;
    d_code  = SZ_12;
    pend    = 1'b0;
    pend_lo = pend_lo_q;
    if (pend_q) begin
      d_vld  = 1'b1;
      d_data = pend_lo_q;
      d_code = SZ_CRC;
    end else if (cl_vld_i) begin
      if (cl_crc_i) begin
        if (cl_len_i == LEN_W'(LEN_CRC)) begin
          d_vld   = 1'b1;
          d_data  = cl_bits_i[ACC_W-1 -: OUT_W];
          d_code  = SZ_CRC;
          pend    = 1'b1;
          pend_lo = cl_bits_i[OUT_W-1:0];
        end
      end else if (cl_len_i == LEN_W'(LEN_SHORT)) begin
        d_vld  = 1'b1;
        d_data = {cl_bits_i[LEN_SHORT-1:0], {(OUT_W-LEN_SHORT){1'b0}}};
        d_code = SZ_12;
      end else if (cl_len_i == LEN_W'(LEN_MID)) begin
        d_vld  = 1'b1;
        d_data = {cl_bits_i[LEN_MID-1:0], {(OUT_W-LEN_MID){1'b0}}};
        d_code = SZ_14;
      end else if (cl_len_i == LEN_W'(LEN_FULL)) begin
        d_vld  = 1'b1;
        d_data = cl_bits_i[LEN_FULL-1:0];
        d_code = SZ_16;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_vld_q   <= 1'b0;
      d_data_q  <= '0;
      d_code_q  <= SZ_12;
      pend_q    <= 1'b0;
      pend_lo_q <= '0;
      o_vld_q   <= 1'b0;
      o_data_q  <= '0;
    end else begin
      d_vld_q   <= d_vld;
      d_data_q  <= d_data;
      d_code_q  <= d_code;
      pend_q    <= pend;
      pend_lo_q <= pend_lo;
      o_vld_q   <= d_vld_q;
      if (d_vld_q) o_data_q <= {d_code_q, d_data_q};
    end
  end

  assign beat_vld_o  = o_vld_q;
  assign beat_data_o = o_data_q;

  // R8
  crc_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d_vld_q && d_code_q == SZ_CRC && pend_q |=> d_vld_q && d_code_q == SZ_CRC && !pend_q);

  // R8
  crc_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> !cl_vld_i);

  // R9
  drop_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cl_vld_i && !cl_crc_i && !pend_q && cl_len_i != LEN_W'(LEN_SHORT)
      && cl_len_i != LEN_W'(LEN_MID) && cl_len_i != LEN_W'(LEN_FULL) |=> !d_vld_q);
endmodule

// File: rtl/lvds_word_assembler.sv
module lvds_word_assembler
  import lvds_wa_pkg::*;
#(
  parameter int unsigned SLICE_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [SLICE_W-1:0] data_i,
  input  logic [SLICE_W-1:0] frame_i,
  input  logic [SLICE_W-1:0] valid_i,
  output logic               m_tvalid_o,
  output logic [BEAT_W-1:0]  m_tdata_o
);
  logic [SLICE_W-1:0] al_d, al_f, al_v;
  logic               cl_vld, cl_crc;
  logic [ACC_W-1:0]   cl_bits;
  logic [LEN_W-1:0]   cl_len;

  lvds_wa_aligner #(.SLICE_W(SLICE_W)) u_aligner (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .data_i     (data_i),
    .frame_i    (frame_i),
    .valid_i    (valid_i),
    .al_data_o  (al_d),
    .al_frame_o (al_f),
    .al_valid_o (al_v)
  );

  lvds_wa_packer #(.SLICE_W(SLICE_W)) u_packer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .al_data_i  (al_d),
    .al_frame_i (al_f),
    .al_valid_i (al_v),
    .cl_vld_o   (cl_vld),
    .cl_bits_o  (cl_bits),
    .cl_len_o   (cl_len),
    .cl_crc_o   (cl_crc)
  );

  lvds_wa_formatter u_formatter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cl_vld_i    (cl_vld),
    .cl_bits_i   (cl_bits),
    .cl_len_i    (cl_len),
    .cl_crc_i    (cl_crc),
    .beat_vld_o  (m_tvalid_o),
    .beat_data_o (m_tdata_o)
  );
endmodule

// File: tb/lvds_word_assembler_bench.sv
module lvds_word_assembler_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  data_i = '0, frame_i = '0, valid_i = '0;
  logic        m_tvalid_o;
  logic [17:0] m_tdata_o;

  always #2 clk_i = ~clk_i;

  lvds_word_assembler u_lvds_word_assembler (
    .clk_i(clk_i), .rst_ni(rst_ni), .data_i(data_i), .frame_i(frame_i),
    .valid_i(valid_i), .m_tvalid_o(m_tvalid_o), .m_tdata_o(m_tdata_o)
  );

  int n_chk = 0, n_fail = 0, cyc = 0, cyc0 = 0, phase_o = 0;
  bit done = 0;
  bit qd[$], qf[$], qv[$];
  logic [17:0] exp_q[$], got_q[$];
  string       tag_q[$];
  int          got_cyc[$];

  always @(posedge clk_i) cyc <= cyc + 1;
  always @(negedge clk_i) if (rst_ni && m_tvalid_o) begin
    got_q.push_back(m_tdata_o);
    got_cyc.push_back(cyc);
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic new_stream(int o);
    qd.delete(); qf.delete(); qv.delete();
    exp_q.delete(); tag_q.delete();
    phase_o = o;
  endtask

  task automatic add_idle(int n);
    for (int k = 0; k < n; k++) begin
      int i = qd.size();
      qd.push_back(1'b0);
      qf.push_back(((i + 8 - phase_o) % 8) < 4);
      qv.push_back(1'b0);
    end
  endtask

  task automatic gap();
    add_idle(8);
    while (((qd.size() + 8 - phase_o) % 8) != 0) add_idle(1);
  endtask

  task automatic add_word(logic [31:0] val, int len);
    for (int k = len - 1; k >= 0; k--) begin
      qd.push_back(val[k]);
      qf.push_back((len - 1 - k) < len / 2);
      qv.push_back(1'b1);
    end
  endtask

  task automatic add_s(logic [31:0] val, int len, string tag);
    add_word(val, len);
    if (len == 12) exp_q.push_back({2'b00, val[11:0], 4'b0});
    else if (len == 14) exp_q.push_back({2'b01, val[13:0], 2'b0});
    else if (len == 16) exp_q.push_back({2'b10, val[15:0]});
    if (len == 12 || len == 14 || len == 16) tag_q.push_back(tag);
  endtask

  task automatic add_crc(logic [31:0] val, string tag);
    add_word(val, 32);
    exp_q.push_back({2'b11, val[31:16]}); tag_q.push_back(tag);
    exp_q.push_back({2'b11, val[15:0]});  tag_q.push_back(tag);
  endtask

  task automatic play();
    add_idle(40);
    while ((qd.size() % 8) != 0) add_idle(1);
    got_q.delete(); got_cyc.delete();
    @(negedge clk_i);
    rst_ni = 1'b0; data_i = '0; frame_i = '0; valid_i = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    cyc0 = cyc;
    for (int n = 0; n < qd.size() / 8; n++) begin
      if (n > 0) @(negedge clk_i);
      for (int j = 0; j < 8; j++) begin
        data_i[7-j]  = qd[8*n+j];
        frame_i[7-j] = qf[8*n+j];
        valid_i[7-j] = qv[8*n+j];
      end
    end
    @(negedge clk_i);
    data_i = '0; frame_i = '0; valid_i = '0;
    repeat (10) @(negedge clk_i);
  endtask

  task automatic compare(string req);
    check({req, " beat count"}, got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      check(tag_q[i], got_q[i], exp_q[i]);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    check("R1 tvalid in reset", m_tvalid_o, 0);
    check("R1 tdata in reset", m_tdata_o, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R1 tvalid after release", m_tvalid_o, 0);
    check("R1 tdata after release", m_tdata_o, 0);
  endtask

  task automatic t_sizes();
    new_stream(0);
    add_idle(48);
    add_s(32'hABC, 12, "R4"); add_s(32'h5A3, 12, "R4");
    gap(); add_crc(32'hDEADBEEF, "R8");
    gap(); add_s(32'h2F0F, 14, "R5"); add_s(32'h1234, 14, "R5");
    gap(); add_crc(32'h0BADF00D, "R8");
    gap(); add_s(32'hC3A5, 16, "R6"); add_s(32'h8001, 16, "R6");
    gap(); add_crc(32'h13579BDF, "R8");
    play();
    compare("R4 R5 R6 R8 sizes");
  endtask

  task automatic t_offsets();
    for (int o = 1; o < 8; o++) begin
      new_stream(o);
      add_idle(48); gap();
      add_s(32'h9C1 + o, 12, "R3"); add_s(32'hF00F, 16, "R3");
      add_s(32'h3ABC, 14, "R3");    add_s(32'h0F7, 12, "R3");
      gap(); add_crc(32'hCAFE0000 + o, "R3");
      play();
      compare("R3 offset");
    end
  endtask

  task automatic t_nolock();
    new_stream(0);
    for (int k = 0; k < 24; k++) add_word(32'h1111 * k, 16);
    add_idle(48); gap();
    add_s(32'h4321, 16, "R2");
    play();
    compare("R2 lock");
  endtask

  task automatic t_illegal();
    new_stream(0);
    add_idle(48);
    add_s(32'h111, 12, "R9"); add_s(32'h1ABC, 13, "R9"); add_s(32'hBEEF, 16, "R9");
    gap(); add_word(32'hABCDEF, 24);
    gap(); add_s(32'h0777, 14, "R9");
    play();
    compare("R9 odd lengths");
  endtask

  task automatic t_latency();
    int c1, c2;
    new_stream(0);
    add_idle(48);
    add_s(32'h5E5, 12, "R10");
    c1 = qd.size();
    gap(); add_crc(32'h89ABCDEF, "R10");
    c2 = qd.size();
    play();
    compare("R10 latency");
    if (got_cyc.size() == 3) begin
      check("R10 word cycle", got_cyc[0], cyc0 + c1 / 8 + 5);
      check("R10 crc upper cycle", got_cyc[1], cyc0 + c2 / 8 + 5);
      check("R10 crc lower cycle", got_cyc[2], cyc0 + c2 / 8 + 6);
    end
  endtask

  initial begin
    t_reset();
    t_sizes();
    t_offsets();
    t_nolock();
    t_illegal();
    t_latency();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule